// File: doc/BRIEF.md
# Deferred-Fault Commit Unit

This block carries out commit and clear operations on a bank of deferred-fault flags. Instructions that are allowed to fault without trapping leave a flag set on their destination register instead, along with a fault-status record that names the register and whether it is a float or a general register. A later commit checks whether the named register, or the whole bank, still carries a deferred fault. If it does, and logging is on, the commit raises an exception. A clear-only request does the same cleanup without raising anything.

A request carries a target index and a float/general select. A target with its sign bit set means every register. Two availability inputs say whether the upper and lower halves of the bank may be touched. When a request is accepted, the block latches the selected 64-bit flag bank. It decides whether a fault is pending and writes the cleaned bank back once. When logging is on, it then walks the status records one per cycle and strobes a clear for each record that matches. Each strobe clears the status record and its paired address register. At the end it pulses `done`, and pulses `commit_exc` with it when the request faults.

The controller has four states: `ST_IDLE` (ready; `req_valid` moves to `ST_EVAL`), `ST_EVAL` (evaluate and write the flags; it moves to `ST_SCAN` when the target is reachable and logging is on, and to `ST_DONE` otherwise), `ST_SCAN` (one record per cycle; after the last record it moves to `ST_DONE`) and `ST_DONE` (the result pulse; it always returns to `ST_IDLE`).

Top module: `ne_commit_unit`

## Requirements
- R1: For a target index of 0 or more, the request is pending exactly when that register's flag in the latched bank is 1.
- R2: For an all-registers target (bit 6 of `req_target` set), the request is pending when the upper half (bits 63..32) is available and nonzero, or when the lower half (bits 31..0) is available and nonzero. A half that is not available never makes the request pending.
- R3: If the target is reachable, `flags_we` is high for exactly one cycle, the first cycle after the accepting edge. `flags_out` then equals the latched bank with the target bit cleared (single target) or with every available half zeroed (all registers). `flags_we_float` repeats the request's float select.
- R4: `commit_exc` pulses only together with `done`. It pulses only for a commit request whose target was pending, and only while both `ctl_valid` and `ctl_log_en` are 1.
- R5: When logging is on, record i gets a clear strobe on `rec_clr[i]` if all of these hold: i < `ctl_count`, `rec_valid[i]` is set, `rec_float[i]` equals the request's select, and, for a single target, destination field i (`rec_dest` bits 6i+5..6i) equals the target. At most one strobe is high in any cycle, and no strobe fires while logging is off.
- R6: A clear-only request (`req_commit`=0) clears flags and records exactly as a commit would, and never raises `commit_exc`.
- R7: A single target in an unavailable half (upper half for index 32..63) writes no flags, clears no record and raises no exception. It still completes with `done`.
- R8: `done` is a one-cycle pulse. Counting the cycle that starts at the accepting edge as cycle 1, it falls in cycle NREC+2 when a scan runs and in cycle 2 otherwise.
- R9: `req_ready` is high only in the idle state. It drops for the whole operation after an accept and returns in the cycle after `done`.
- R10: After reset, `req_ready` is 1 and `done`, `commit_exc`, `flags_we` and `rec_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting |
| req_commit | input | 1 | 1 = commit, 0 = clear only |
| req_float | input | 1 | 1 = float bank, 0 = general bank |
| req_target | input | IDX_W+1 | Target register; top bit set means all registers |
| avail_hi | input | 1 | Upper half of the bank accessible |
| avail_lo | input | 1 | Lower half of the bank accessible |
| gen_flags | input | BANK_W | Current general-register fault flags |
| fp_flags | input | BANK_W | Current float-register fault flags |
| ctl_valid | input | 1 | Record control valid |
| ctl_log_en | input | 1 | Record logging enabled |
| ctl_count | input | CNT_W | Number of records in use |
| rec_valid | input | NREC | Record valid bits |
| rec_float | input | NREC | Record float bits |
| rec_dest | input | NREC*IDX_W | Record destination numbers, packed |
| flags_we | output | 1 | Write strobe for the cleaned bank |
| flags_we_float | output | 1 | Bank selected by the write |
| flags_out | output | BANK_W | Cleaned flag bank |
| rec_clr | output | NREC | Clear strobe for a status record and its address register |
| commit_exc | output | 1 | Commit exception pulse |
| done | output | 1 | Operation complete |

## Verification
Pending detection is tried four ways: a single target whose flag is set, one whose flag is clear, an all-registers request with both halves open, and an all-registers request whose only set flags lie in a closed half. The last case shows whether availability really gates the OR across halves. The record walk runs against a mix of records that differ in validity, type and destination, then again with a reduced record count and with the float bank. This shows whether each match term and the count limit take part. Turning off each control bit in turn, issuing a clear-only request and aiming at a closed half show that the exception, the scan and the flag write are each suppressed for their own reason, with the latency dropping to two cycles.

// File: rtl/ne_commit_pkg.sv
package ne_commit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_SCAN = 2'd2,
        ST_DONE = 2'd3
    } ne_state_e;

endpackage

// File: rtl/ne_pending_eval.sv
module ne_pending_eval #(
    parameter int BANK_W = 64,
    localparam int IDX_W = $clog2(BANK_W)
) (
    input  logic [BANK_W-1:0] bank_in,
    input  logic              all_regs,
    input  logic [IDX_W-1:0]  idx,
    input  logic              avail_hi,
    input  logic              avail_lo,
    output logic              target_ok,
    output logic              pending,
    output logic [BANK_W-1:0] bank_out
);
    localparam int HALF = BANK_W / 2;

    logic hi_any;
    logic lo_any;

    assign hi_any = |bank_in[BANK_W-1:HALF];
    assign lo_any = |bank_in[HALF-1:0];

    always_comb begin
        bank_out = bank_in;
        if (all_regs) begin
            target_ok = 1'b1;
            pending   = (avail_hi && hi_any) || (avail_lo && lo_any);
            if (avail_hi) bank_out[BANK_W-1:HALF] = '0;
            if (avail_lo) bank_out[HALF-1:0]      = '0;
        end else begin
            // upper half selected by the index MSB
            target_ok     = idx[IDX_W-1] ? avail_hi : avail_lo;
            pending       = bank_in[idx];
            bank_out[idx] = 1'b0;
        end
    end

endmodule

// File: rtl/ne_rec_match.sv
module ne_rec_match #(
    parameter int NREC  = 8,
    parameter int IDX_W = 6,
    localparam int CNT_W = $clog2(NREC + 1)
) (
    input  logic [NREC-1:0]       rec_valid,
    input  logic [NREC-1:0]       rec_float,
    input  logic [NREC*IDX_W-1:0] rec_dest,
    input  logic [CNT_W-1:0]      count,
    input  logic                  req_float,
    input  logic                  all_regs,
    input  logic [IDX_W-1:0]      idx,
    output logic [NREC-1:0]       match
);
    for (genvar i = 0; i < NREC; i++) begin : g_rec
        logic in_range;
        logic dest_hit;
        assign in_range = CNT_W'(i) < count;
        assign dest_hit = all_regs || (rec_dest[i*IDX_W +: IDX_W] == idx);
        assign match[i] = in_range && rec_valid[i] &&
                          (rec_float[i] == req_float) && dest_hit;
    end

endmodule

// File: rtl/ne_commit_unit.sv
module ne_commit_unit
    import ne_commit_pkg::*;
#(
    parameter int BANK_W = 64,
    parameter int NREC   = 8,
    localparam int IDX_W = $clog2(BANK_W),
    localparam int CNT_W = $clog2(NREC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_commit,
    input  logic                  req_float,
    input  logic [IDX_W:0]        req_target,
    input  logic                  avail_hi,
    input  logic                  avail_lo,
    input  logic [BANK_W-1:0]     gen_flags,
    input  logic [BANK_W-1:0]     fp_flags,
    input  logic                  ctl_valid,
    input  logic                  ctl_log_en,
    input  logic [CNT_W-1:0]      ctl_count,
    input  logic [NREC-1:0]       rec_valid,
    input  logic [NREC-1:0]       rec_float,
    input  logic [NREC*IDX_W-1:0] rec_dest,
    output logic                  flags_we,
    output logic                  flags_we_float,
    output logic [BANK_W-1:0]     flags_out,
    output logic [NREC-1:0]       rec_clr,
    output logic                  commit_exc,
    output logic                  done
);
    localparam int SCAN_W = (NREC > 1) ? $clog2(NREC) : 1;
    localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(NREC - 1);

    ne_state_e          state_q, state_d;
    logic [SCAN_W-1:0]  scan_q;
    logic               cmt_q, flt_q, all_q;
    logic [IDX_W-1:0]   idx_q;
    logic [BANK_W-1:0]  bank_q;
    logic               pend_q, log_q;

    logic               ev_ok, ev_pend;
    logic [BANK_W-1:0]  ev_bank;
    logic [NREC-1:0]    match;
    logic               log_en;

    assign log_en = ctl_valid && ctl_log_en;

    ne_pending_eval #(.BANK_W(BANK_W)) u_eval (
        .bank_in   (bank_q),
        .all_regs  (all_q),
        .idx       (idx_q),
        .avail_hi  (avail_hi),
        .avail_lo  (avail_lo),
        .target_ok (ev_ok),
        .pending   (ev_pend),
        .bank_out  (ev_bank)
    );

    ne_rec_match #(.NREC(NREC), .IDX_W(IDX_W)) u_match (
        .rec_valid (rec_valid),
        .rec_float (rec_float),
        .rec_dest  (rec_dest),
        .count     (ctl_count),
        .req_float (flt_q),
        .all_regs  (all_q),
        .idx       (idx_q),
        .match     (match)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = (ev_ok && log_en) ? ST_SCAN : ST_DONE;
            ST_SCAN: if (scan_q == SCAN_LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture, evaluation results and record walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= '0;
            cmt_q  <= 1'b0;
            flt_q  <= 1'b0;
            all_q  <= 1'b0;
            idx_q  <= '0;
            bank_q <= '0;
            pend_q <= 1'b0;
            log_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                cmt_q  <= req_commit;
                flt_q  <= req_float;
                all_q  <= req_target[IDX_W];
                idx_q  <= req_target[IDX_W-1:0];
                bank_q <= req_float ? fp_flags : gen_flags;
            end
            if (state_q == ST_EVAL) begin
                pend_q <= ev_pend && ev_ok;
                log_q  <= log_en;
            end
            if (state_q == ST_SCAN) scan_q <= scan_q + 1'b1;
            else                    scan_q <= '0;
        end
    end

    // outputs
    always_comb begin
        req_ready      = 1'b0;
        flags_we       = 1'b0;
        flags_we_float = flt_q;
        flags_out      = ev_bank;
        rec_clr        = '0;
        commit_exc     = 1'b0;
        done           = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_EVAL: flags_we  = ev_ok;
            ST_SCAN: rec_clr[scan_q] = match[scan_q];
            ST_DONE: begin
                done       = 1'b1;
                commit_exc = cmt_q && pend_q && log_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ne_commit_unit_chk.sv
module ne_commit_unit_chk #(
    parameter int NREC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            ctl_valid,
    input logic            ctl_log_en,
    input logic            flags_we,
    input logic [NREC-1:0] rec_clr,
    input logic            commit_exc,
    input logic            done
);
    p_clr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rec_clr));

    p_clr_needs_log_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|rec_clr) |-> (ctl_valid && ctl_log_en));

    p_exc_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_exc |-> done);

    p_exc_needs_log_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_exc |-> (ctl_valid && ctl_log_en));

    p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |=> !flags_we);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

endmodule

bind ne_commit_unit ne_commit_unit_chk #(.NREC(NREC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ctl_valid  (ctl_valid),
    .ctl_log_en (ctl_log_en),
    .flags_we   (flags_we),
    .rec_clr    (rec_clr),
    .commit_exc (commit_exc),
    .done       (done)
);

// File: tb/ne_commit_unit_tb.sv
`timescale 1ns/1ps
module ne_commit_unit_tb;
    localparam int BANK_W = 64;
    localparam int NREC   = 8;
    localparam int IDX_W  = 6;
    localparam int CNT_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_commit = 1'b0, req_float = 1'b0;
    logic [IDX_W:0] req_target = '0;
    logic avail_hi = 1'b1, avail_lo = 1'b1;
    logic [BANK_W-1:0] gen_flags = '0, fp_flags = '0;
    logic ctl_valid = 1'b1, ctl_log_en = 1'b1;
    logic [CNT_W-1:0] ctl_count = CNT_W'(NREC);
    logic [NREC-1:0] rec_valid = '0, rec_float = '0;
    logic [NREC*IDX_W-1:0] rec_dest = '0;
    logic req_ready, flags_we, flags_we_float, commit_exc, done;
    logic [BANK_W-1:0] flags_out;
    logic [NREC-1:0] rec_clr;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ne_commit_unit #(.BANK_W(BANK_W), .NREC(NREC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_commit(req_commit), .req_float(req_float), .req_target(req_target),
        .avail_hi(avail_hi), .avail_lo(avail_lo), .gen_flags(gen_flags),
        .fp_flags(fp_flags), .ctl_valid(ctl_valid), .ctl_log_en(ctl_log_en),
        .ctl_count(ctl_count), .rec_valid(rec_valid), .rec_float(rec_float),
        .rec_dest(rec_dest), .flags_we(flags_we), .flags_we_float(flags_we_float),
        .flags_out(flags_out), .rec_clr(rec_clr), .commit_exc(commit_exc),
        .done(done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_rec(input int i, input bit v, input bit f, input int d);
        rec_valid[i] = v;
        rec_float[i] = f;
        rec_dest[i*IDX_W +: IDX_W] = IDX_W'(d);
    endtask

    // issue one request, model the expected result, compare
    task automatic do_req(input bit commit, input bit flt, input int tgt,
                          input string tag);
        logic [63:0] bank, nb, expclr;
        bit all, ok, pend, logen, expexc;
        int explat;
        logic [63:0] got_flags = '0;
        logic [NREC-1:0] clr_or = '0;
        int we_cnt = 0, lat = 0, rdy_busy = 0;
        bit exc_seen = 0, wf = 0;
        bank  = flt ? fp_flags : gen_flags;
        all   = tgt < 0;
        nb    = bank;
        logen = ctl_valid && ctl_log_en;
        if (all) begin
            ok   = 1;
            pend = (avail_hi && (bank[63:32] != 0)) || (avail_lo && (bank[31:0] != 0));
            if (avail_hi) nb[63:32] = '0;
            if (avail_lo) nb[31:0]  = '0;
        end else begin
            ok   = (tgt >= 32) ? avail_hi : avail_lo;
            pend = bank[tgt];
            nb[tgt] = 1'b0;
        end
        expclr = '0;
        if (ok && logen)
            for (int i = 0; i < NREC; i++)
                if (i < int'(ctl_count) && rec_valid[i] && rec_float[i] == flt &&
                    (all || int'(rec_dest[i*IDX_W +: IDX_W]) == tgt))
                    expclr[i] = 1'b1;
        expexc = commit && ok && pend && logen;
        explat = (ok && logen) ? NREC + 2 : 2;

        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 idle ready"}, 64'(req_ready), 64'd1);
        req_commit = commit;
        req_float  = flt;
        req_target = (IDX_W+1)'(tgt);
        req_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 1; n <= 40; n++) begin
            if (flags_we) begin we_cnt++; got_flags = flags_out; wf = flags_we_float; end
            clr_or |= rec_clr;
            if (commit_exc) exc_seen = 1;
            if (done) begin lat = n; break; end
            if (req_ready) rdy_busy++;
            @(negedge clk);
        end
        chk(we_cnt == int'(ok), {tag, " R3/R7 flag writes"}, 64'(we_cnt), 64'(ok));
        if (ok) begin
            chk(got_flags == nb, {tag, " R3 flags_out"}, got_flags, nb);
            chk(wf == flt, {tag, " R3 write bank"}, 64'(wf), 64'(flt));
        end
        chk(64'(clr_or) == expclr, {tag, " R5 record clears"}, 64'(clr_or), expclr);
        chk(exc_seen == expexc, {tag, " R4/R6 commit_exc"}, 64'(exc_seen), 64'(expexc));
        chk(lat == explat, {tag, " R8 done latency"}, 64'(lat), 64'(explat));
        chk(rdy_busy == 0, {tag, " R9 ready while busy"}, 64'(rdy_busy), 64'd0);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 ready after done"}, 64'(req_ready), 64'd1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10 ready", 64'(req_ready), 64'd1);
        chk({done, commit_exc, flags_we} == 3'b0, "R10 pulses", 64'({done, commit_exc, flags_we}), 64'd0);
        chk(rec_clr == '0, "R10 rec_clr", 64'(rec_clr), 64'd0);
    endtask

    task automatic t_records();
        rec_valid = '0; rec_float = '0; rec_dest = '0;
        set_rec(0, 1, 0, 5);
        set_rec(1, 1, 1, 5);
        set_rec(2, 1, 0, 7);
        set_rec(3, 0, 0, 5);
        set_rec(4, 1, 0, 5);
        set_rec(6, 1, 0, 40);
    endtask

    task automatic t_single_pending();   // R1 R4 R5
        gen_flags = 64'h0000_0100_0000_0020;
        do_req(1, 0, 5, "single pending R1");
    endtask

    task automatic t_single_clear_bit(); // R1
        gen_flags = 64'h0000_0000_0000_0020;
        do_req(1, 0, 7, "single not pending R1");
    endtask

    task automatic t_all_both();         // R2
        gen_flags = 64'h0000_0100_0000_0000;
        do_req(1, 0, -1, "all both halves R2");
    endtask

    task automatic t_all_hi_closed();    // R2
        avail_hi = 0;
        gen_flags = 64'h8000_0000_0000_0000;
        do_req(1, 0, -1, "all hi closed R2");
        avail_hi = 1;
    endtask

    task automatic t_count_limit();      // R5
        ctl_count = 3;
        gen_flags = 64'h20;
        do_req(1, 0, 5, "count limit R5");
        ctl_count = CNT_W'(NREC);
    endtask

    task automatic t_float_bank();       // R5
        fp_flags = 64'h20;
        do_req(1, 1, 5, "float bank R5");
    endtask

    task automatic t_log_off();          // R4 R8
        ctl_log_en = 0;
        gen_flags = 64'h20;
        do_req(1, 0, 5, "log enable off R4");
        ctl_log_en = 1;
        ctl_valid = 0;
        do_req(1, 0, 5, "ctl invalid R4");
        ctl_valid = 1;
    endtask

    task automatic t_clear_only();       // R6
        gen_flags = 64'h0000_0100_0000_0020;
        do_req(0, 0, 5, "clear only R6");
        do_req(0, 0, -1, "clear only all R6");
    endtask

    task automatic t_unavailable();      // R7
        avail_hi = 0;
        gen_flags = 64'h0000_0100_0000_0000;
        do_req(1, 0, 40, "closed half R7");
        avail_hi = 1;
        avail_lo = 0;
        gen_flags = 64'h20;
        do_req(1, 0, 5, "closed lower R7");
        avail_lo = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_records();
        t_single_pending();
        t_single_clear_bit();
        t_all_both();
        t_all_hi_closed();
        t_count_limit();
        t_float_bank();
        t_log_off();
        t_clear_only();
        t_unavailable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule